// File: doc/BRIEF.md
# Sleep State Controller

This block decides when a small microcontroller core may stop its clocks and when it must start them again. The core raises a one-cycle pulse when it executes its sleep instruction. The block looks at a sleep-enable bit and a two-bit mode select. It then moves into one of three low-power states: Idle, ADC quiet, or Power-down. In each state it drives three clock enables, one for the CPU, one for the I/O peripherals (timers, comparator, interrupt logic) and one for the ADC and clock system.

Each state accepts its own set of wake-up requests. In Power-down, the level and pin-change requests only count once they have been seen on two consecutive ticks of the slow watchdog-oscillator clock. That clock reaches the block as a one-cycle `slowTick` strobe. A Power-down exit then waits a selectable number of slow ticks while the oscillator settles. Every wake from an interrupt ends with a fixed CPU halt. After the halt, a one-cycle pulse tells the core to service the interrupt and then carry on after the sleep instruction. Reset ends any sleep at once.

Top module: `sleep_ctl`

## Requirements
- R1: After reset the block is awake: `cpuClkEn`, `ioClkEn` and `adcClkEn` are all 1, and `adcStart` and `wakeIrq` are 0.
- R2: A `sleepInstr` pulse is a no-op when `sleepEn` is 0 or when `modeSel` is 2'b11. The clock enables stay at 1.
- R3: `modeSel` 2'b00 selects Idle, 2'b01 selects ADC quiet and 2'b10 selects Power-down. In the cycle after the entry edge, the enables {cpu,io,adc} are 011 for Idle, 001 for ADC quiet and 000 for Power-down.
- R4: On entry to Idle or ADC quiet with `adcEnabled` at 1, `adcStart` is high for exactly the one cycle after the entry edge. It never pulses on entry to Power-down.
- R5: In Idle, any of `irqAny`, `irqExtLevel`, `irqPinChg` or `irqAdc` wakes the block on the next clock edge.
- R6: In ADC quiet, `irqExtLevel`, `irqPinChg` and `irqAdc` wake the block on the next edge. `irqAny` on its own is ignored.
- R7: In Power-down, only `irqExtLevel` or `irqPinChg` can wake the block. The request must be high on two consecutive `slowTick` strobes, and the wake is taken at the second one. `irqAny` and `irqAdc` are ignored, and so is any request between ticks.
- R8: After a Power-down wake, all three enables stay 0 for a restart delay of `delaySel` slow ticks: 0 for 2'b00, 16 for 2'b01, 64 for 2'b10 and 256 for 2'b11. The halt starts after the last tick.
- R9: Every wake passes through a halt of 4 clock cycles with `cpuClkEn`=0 and `ioClkEn`=`adcClkEn`=1. Then `cpuClkEn` returns to 1 and `wakeIrq` is high for exactly that first running cycle.
- R10: Asserting `rstN` low during any sleep state returns the block to the awake state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepEn | input | 1 | Sleep-enable bit |
| modeSel | input | 2 | Sleep mode select |
| sleepInstr | input | 1 | One-cycle pulse: sleep instruction executed |
| adcEnabled | input | 1 | ADC is switched on |
| irqAny | input | 1 | Any other enabled interrupt (timers, comparator, watchdog) |
| irqExtLevel | input | 1 | External level interrupt request |
| irqPinChg | input | 1 | Pin-change interrupt request |
| irqAdc | input | 1 | ADC conversion-complete interrupt |
| slowTick | input | 1 | One-cycle strobe per watchdog-oscillator period |
| delaySel | input | 2 | Restart-delay select |
| cpuClkEn | output | 1 | CPU clock enable |
| ioClkEn | output | 1 | I/O peripheral clock enable |
| adcClkEn | output | 1 | ADC and clock-system enable |
| adcStart | output | 1 | Automatic conversion-start pulse |
| wakeIrq | output | 1 | Pulse: halt over, service the interrupt |

## Verification
The bench targets the Power-down filter in three ways: a request that is high on one tick and low on the next, a request that toggles between ticks, and a request with no ticks at all. A filter that sampled only once, or that sampled the system clock, would wake on these. It also sweeps the mode and wake-source pairs. A wrong per-mode mask would let `irqAny` end ADC quiet, or `irqAdc` end Power-down. The 16-, 64- and 256-tick delays are counted one tick at a time, so an off-by-one counter would raise a clock enable a tick early or late. The four-cycle halt is counted as well, so a short halt or a `wakeIrq` pulse in the wrong cycle would show up.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;

  localparam int DELAY_W = 9;

  typedef enum logic [2:0] {
    PS_RUN, PS_IDLE, PS_QUIET, PS_PDOWN, PS_RESTART, PS_HALT
  } pwrState_t;

  localparam logic [1:0] MODE_IDLE  = 2'b00;
  localparam logic [1:0] MODE_QUIET = 2'b01;
  localparam logic [1:0] MODE_PDOWN = 2'b10;

  typedef struct packed {
    logic clearFilter;
    logic loadDelay;
    logic countDelay;
    logic loadHalt;
    logic countHalt;
  } ctrlStrobe_t;

  typedef struct packed {
    logic pdWake;
    logic delayZero;
    logic delayDone;
    logic haltDone;
  } dpStatus_t;

  function automatic logic [DELAY_W-1:0] delayTicks(input logic [1:0] sel);
    if (sel == 2'b00) delayTicks = '0;
    else delayTicks = DELAY_W'(1) << (2 * int'(sel) + 2);
  endfunction

endpackage

// File: rtl/sleep_ctl_dp.sv
module sleep_ctl_dp
  import sleep_ctl_pkg::*;
#(
  parameter int HALT_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        slowTick,
  input  logic        irqExtLevel,
  input  logic        irqPinChg,
  input  logic [1:0]  delaySel,
  output dpStatus_t   status
);
  localparam int HALT_W = $clog2(HALT_CYCLES + 1);
  localparam logic [HALT_W-1:0] HALT_LOAD = HALT_W'(HALT_CYCLES - 1);

  logic              pdReq;
  logic              sampleQ;
  logic [DELAY_W-1:0] delayCnt;
  logic [HALT_W-1:0]  haltCnt;

  assign pdReq = irqExtLevel | irqPinChg;

  // Slow-clock double sample: first tick stores, second tick confirms.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sampleQ <= 1'b0;
    else if (strobe.clearFilter) sampleQ <= 1'b0;
    else if (slowTick)          sampleQ <= pdReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) delayCnt <= '0;
    else if (strobe.loadDelay) delayCnt <= delayTicks(delaySel);
    else if (strobe.countDelay && slowTick && delayCnt != '0) delayCnt <= delayCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) haltCnt <= '0;
    else if (strobe.loadHalt) haltCnt <= HALT_LOAD;
    else if (strobe.countHalt && haltCnt != '0) haltCnt <= haltCnt - 1'b1;
  end

  assign status.pdWake    = !strobe.clearFilter && slowTick && pdReq && sampleQ;
  assign status.delayZero = (delaySel == 2'b00);
  assign status.delayDone = strobe.countDelay && slowTick && (delayCnt == DELAY_W'(1));
  assign status.haltDone  = strobe.countHalt && (haltCnt == '0);

  // Restart counter only moves on slow ticks.
  assert_delay_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countDelay && !slowTick && !strobe.loadDelay) |=> $stable(delayCnt));

  // Halt counter never exceeds its load value.
  assert_halt_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countHalt |-> (haltCnt <= HALT_LOAD));

endmodule

// File: rtl/sleep_ctl_fsm.sv
module sleep_ctl_fsm
  import sleep_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepEn,
  input  logic [1:0]  modeSel,
  input  logic        sleepInstr,
  input  logic        adcEnabled,
  input  logic        irqAny,
  input  logic        irqExtLevel,
  input  logic        irqPinChg,
  input  logic        irqAdc,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        cpuClkEn,
  output logic        ioClkEn,
  output logic        adcClkEn,
  output logic        adcStart,
  output logic        wakeIrq
);
  pwrState_t state, stateNext;
  logic      startConv;
  logic      quietWake;

  assign quietWake = irqExtLevel | irqPinChg | irqAdc;

  always_comb begin
    stateNext         = state;
    startConv         = 1'b0;
    strobe            = '0;
    strobe.clearFilter = (state != PS_PDOWN);
    strobe.countDelay  = (state == PS_RESTART);
    strobe.countHalt   = (state == PS_HALT);
    unique case (state)
      PS_RUN: if (sleepInstr && sleepEn) begin
        unique case (modeSel)
          MODE_IDLE:  begin stateNext = PS_IDLE;  startConv = 1'b1; end
          MODE_QUIET: begin stateNext = PS_QUIET; startConv = 1'b1; end
          MODE_PDOWN: stateNext = PS_PDOWN;
          default:    stateNext = PS_RUN;
        endcase
      end
      PS_IDLE: if (irqAny || quietWake) begin
        stateNext = PS_HALT; strobe.loadHalt = 1'b1;
      end
      PS_QUIET: if (quietWake) begin
        stateNext = PS_HALT; strobe.loadHalt = 1'b1;
      end
      PS_PDOWN: if (status.pdWake) begin
        if (status.delayZero) begin stateNext = PS_HALT; strobe.loadHalt = 1'b1; end
        else begin stateNext = PS_RESTART; strobe.loadDelay = 1'b1; end
      end
      PS_RESTART: if (status.delayDone) begin
        stateNext = PS_HALT; strobe.loadHalt = 1'b1;
      end
      PS_HALT: if (status.haltDone) stateNext = PS_RUN;
      default: stateNext = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PS_RUN;
      adcStart <= 1'b0;
      wakeIrq  <= 1'b0;
    end else begin
      state    <= stateNext;
      adcStart <= startConv && adcEnabled;
      wakeIrq  <= (state == PS_HALT) && status.haltDone;
    end
  end

  always_comb begin
    unique case (state)
      PS_RUN:   {cpuClkEn, ioClkEn, adcClkEn} = 3'b111;
      PS_IDLE:  {cpuClkEn, ioClkEn, adcClkEn} = 3'b011;
      PS_QUIET: {cpuClkEn, ioClkEn, adcClkEn} = 3'b001;
      PS_HALT:  {cpuClkEn, ioClkEn, adcClkEn} = 3'b011;
      default:  {cpuClkEn, ioClkEn, adcClkEn} = 3'b000;
    endcase
  end

  // A disabled or reserved sleep request leaves the core running.
  assert_noop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_RUN && sleepInstr && (!sleepEn || modeSel == 2'b11)) |=> (state == PS_RUN));

  // Conversion start only while the ADC domain runs and the CPU is stopped.
  assert_adc_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> (adcClkEn && !cpuClkEn));

  // ADC quiet mode ignores the general interrupt line.
  assert_quiet_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_QUIET && !quietWake) |=> (state == PS_QUIET));

  // Power-down never returns straight to running.
  assert_pdown_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_PDOWN) |=> (state inside {PS_PDOWN, PS_RESTART, PS_HALT}));

  // The service pulse follows the halt.
  assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> (cpuClkEn && $past(state == PS_HALT)));

endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import sleep_ctl_pkg::*;
#(
  parameter int HALT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepEn,
  input  logic [1:0] modeSel,
  input  logic       sleepInstr,
  input  logic       adcEnabled,
  input  logic       irqAny,
  input  logic       irqExtLevel,
  input  logic       irqPinChg,
  input  logic       irqAdc,
  input  logic       slowTick,
  input  logic [1:0] delaySel,
  output logic       cpuClkEn,
  output logic       ioClkEn,
  output logic       adcClkEn,
  output logic       adcStart,
  output logic       wakeIrq
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  sleep_ctl_fsm fsm_i (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .modeSel(modeSel),
    .sleepInstr(sleepInstr), .adcEnabled(adcEnabled), .irqAny(irqAny),
    .irqExtLevel(irqExtLevel), .irqPinChg(irqPinChg), .irqAdc(irqAdc),
    .status(status), .strobe(strobe), .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn),
    .adcClkEn(adcClkEn), .adcStart(adcStart), .wakeIrq(wakeIrq)
  );

  sleep_ctl_dp #(.HALT_CYCLES(HALT_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slowTick(slowTick),
    .irqExtLevel(irqExtLevel), .irqPinChg(irqPinChg), .delaySel(delaySel),
    .status(status)
  );

endmodule

// File: tb/sleep_ctl_tb.sv
module sleep_ctl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepEn = 1'b0, sleepInstr = 1'b0, adcEnabled = 1'b0;
  logic [1:0] modeSel = 2'b00, delaySel = 2'b00;
  logic irqAny = 1'b0, irqExtLevel = 1'b0, irqPinChg = 1'b0, irqAdc = 1'b0, slowTick = 1'b0;
  logic cpuClkEn, ioClkEn, adcClkEn, adcStart, wakeIrq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_ctl dut_i (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .modeSel(modeSel),
    .sleepInstr(sleepInstr), .adcEnabled(adcEnabled), .irqAny(irqAny),
    .irqExtLevel(irqExtLevel), .irqPinChg(irqPinChg), .irqAdc(irqAdc),
    .slowTick(slowTick), .delaySel(delaySel), .cpuClkEn(cpuClkEn),
    .ioClkEn(ioClkEn), .adcClkEn(adcClkEn), .adcStart(adcStart), .wakeIrq(wakeIrq)
  );

  function automatic logic [2:0] expEn(input int mode);
    case (mode)
      0: expEn = 3'b011;
      1: expEn = 3'b001;
      default: expEn = 3'b000;
    endcase
  endfunction

  // src: 0 irqAny, 1 irqExtLevel, 2 irqPinChg, 3 irqAdc
  function automatic bit wakeAllowed(input int mode, input int src);
    case (mode)
      0: wakeAllowed = 1'b1;
      1: wakeAllowed = (src != 0);
      default: wakeAllowed = (src == 1 || src == 2);
    endcase
  endfunction

  function automatic int delayOf(input int sel);
    delayOf = (sel == 0) ? 0 : (1 << (2 * sel + 2));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkEn(input logic [2:0] exp, input string req);
    chk({cpuClkEn, ioClkEn, adcClkEn} === exp, req, int'({cpuClkEn, ioClkEn, adcClkEn}), int'(exp));
  endtask

  task automatic tick();
    @(negedge clk); slowTick = 1'b1;
    @(negedge clk); slowTick = 1'b0;
  endtask

  task automatic setSrc(input int src, input logic v);
    case (src)
      0: irqAny = v;
      1: irqExtLevel = v;
      2: irqPinChg = v;
      default: irqAdc = v;
    endcase
  endtask

  task automatic enterSleep(input int mode, input bit adcOn);
    @(negedge clk);
    sleepEn = 1'b1; modeSel = 2'(mode); adcEnabled = adcOn; sleepInstr = 1'b1;
    @(negedge clk);
    sleepInstr = 1'b0;
    chkEn(expEn(mode), "R3 entry enables");
    chk(adcStart === (adcOn && mode != 2), "R4 adcStart on entry", int'(adcStart), int'(adcOn && mode != 2));
    @(negedge clk);
    chk(adcStart === 1'b0, "R4 adcStart one cycle", int'(adcStart), 0);
  endtask

  // Called at the first negedge in the halt.
  task automatic haltSeq();
    chkEn(3'b011, "R9 halt enables");
    repeat (3) begin
      @(negedge clk);
      chk(cpuClkEn === 1'b0, "R9 cpu held in halt", int'(cpuClkEn), 0);
    end
    @(negedge clk);
    chk(cpuClkEn === 1'b1 && wakeIrq === 1'b1, "R9 resume with wakeIrq",
        int'({cpuClkEn, wakeIrq}), 3);
    @(negedge clk);
    chk(wakeIrq === 1'b0, "R9 wakeIrq single cycle", int'(wakeIrq), 0);
  endtask

  // Apply a source; returns with the state after the wake edge visible.
  task automatic pulseSrc(input int mode, input int src);
    setSrc(src, 1'b1);
    if (mode == 2) begin tick(); tick(); end
    else @(negedge clk);
    setSrc(src, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h51EE9));
    repeat (3) @(negedge clk);
    chkEn(3'b111, "R1 reset enables");
    chk(adcStart === 0 && wakeIrq === 0, "R1 reset pulses", int'({adcStart, wakeIrq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEn(3'b111, "R1 after reset release");

    // R2: disabled and reserved requests
    sleepEn = 1'b0; modeSel = 2'b10; sleepInstr = 1'b1;
    @(negedge clk); sleepInstr = 1'b0;
    chkEn(3'b111, "R2 sleepEn low no-op");
    sleepEn = 1'b1; modeSel = 2'b11; sleepInstr = 1'b1;
    @(negedge clk); sleepInstr = 1'b0;
    @(negedge clk);
    chkEn(3'b111, "R2 reserved mode no-op");

    // R7: filter corners, delaySel 0 so a wake shows as the halt
    delaySel = 2'b00;
    enterSleep(2, 1'b1);
    irqExtLevel = 1'b1;
    repeat (6) @(negedge clk);
    chkEn(3'b000, "R7 no ticks no wake");
    irqAny = 1'b1; irqAdc = 1'b1;
    irqExtLevel = 1'b0;
    tick(); tick(); tick();
    chkEn(3'b000, "R7 irqAny irqAdc ignored");
    irqAny = 1'b0; irqAdc = 1'b0;
    irqExtLevel = 1'b1; tick();
    irqExtLevel = 1'b0; tick();
    irqExtLevel = 1'b1; tick();
    chkEn(3'b000, "R7 single sample rejected");
    tick();
    irqExtLevel = 1'b0;
    chkEn(3'b011, "R7 second consecutive sample wakes");
    haltSeq();

    // R8: restart delay sweep
    for (int sel = 1; sel < 4; sel++) begin
      delaySel = 2'(sel);
      enterSleep(2, 1'b0);
      irqPinChg = 1'b1; tick(); tick(); irqPinChg = 1'b0;
      for (int t = 1; t < delayOf(sel); t++) begin
        tick();
        if (t == 1 || t == delayOf(sel) - 1)
          chkEn(3'b000, $sformatf("R8 clocks off during delay sel %0d tick %0d", sel, t));
      end
      tick();
      chkEn(3'b011, $sformatf("R8 halt after %0d ticks", delayOf(sel)));
      haltSeq();
    end
    delaySel = 2'b00;

    // R6 directed: irqAny in ADC quiet
    enterSleep(1, 1'b1);
    irqAny = 1'b1;
    repeat (3) @(negedge clk);
    irqAny = 1'b0;
    chkEn(3'b001, "R6 irqAny ignored in quiet");
    pulseSrc(1, 3);
    chkEn(3'b011, "R6 irqAdc wakes quiet");
    haltSeq();

    // R10: reset during power-down and idle
    enterSleep(2, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    chkEn(3'b111, "R10 reset ends power-down");
    rstN = 1'b1;
    enterSleep(0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    chkEn(3'b111, "R10 reset ends idle");
    rstN = 1'b1;
    @(negedge clk);

    // Random mode and source sweep (R3 R4 R5 R6 R7 R9)
    for (int it = 0; it < 40; it++) begin
      int mode = int'($urandom % 3);
      int src  = int'($urandom % 4);
      bit adcOn = 1'($urandom % 2);
      enterSleep(mode, adcOn);
      pulseSrc(mode, src);
      if (wakeAllowed(mode, src)) begin
        chkEn(3'b011, $sformatf("R5/R6/R7 allowed wake mode %0d src %0d", mode, src));
      end else begin
        chkEn(expEn(mode), $sformatf("R6/R7 masked mode %0d src %0d", mode, src));
        pulseSrc(mode, 2);
        chkEn(3'b011, "R5 pin change wake");
      end
      haltSeq();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule